// File: doc/BRIEF.md
# Quadword Access Splitting Sequencer

This block accepts a single 128-bit load or store request and carries it out as two back-to-back 64-bit memory operations. It calculates the effective address of each half. It picks which register of the even/odd pair each half reads or writes. It also tags each half as part of an atomic quadword access when the address allows.

Before any memory traffic starts, the block screens the request for two kinds of fault:

- Illegal register forms.
- Alignment traps. These are chosen so that a fault on the second half can never find the base register already overwritten by the first half.

Memory operations go out on a simple valid/ready port. That port can also report a fault along with the acceptance. One response pulse ends every request: either `done_valid`, or `exc_valid` together with a cause code and the index of the half that faulted.

Top module: `qw_split_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. When a request is accepted with no exception, half 0 is presented on the memory port (`mem_half`=0) in the next cycle. Half 1 follows in the cycle after half 0 is accepted. `done_valid` pulses for one cycle in the cycle after half 1 is accepted, and `req_ready` returns high in the cycle after that. After reset, `req_ready` is 1 and `mem_valid`, `done_valid` and `exc_valid` are 0.
- R2: Half 0 uses the request address. Half 1 uses the request address plus 8. This is done by incrementing bits 63:3, so bits 2:0 are the same in both halves.
- R3: When `req_mode32`=1, bits 63:32 of both half addresses are zero. This is applied after the increment, so 0xFFFFFFF8 becomes 0 for half 1.
- R4: Register order is chosen as follows:
  - If `req_big_endian`=0 and `req_prefixed`=0, half 0 uses rt|1 and half 1 uses rt.
  - Otherwise, half 0 uses rt and half 1 uses rt|1.
  - The same rule applies to loads and stores.
- R5: An odd `req_rt` (bit 0 set) is an illegal form for any request. The block reports `exc_cause`=1 with `exc_half`=0 and issues no memory operation.
- R6: A load (`req_is_store`=0) with `req_ra`=`req_rt` is an illegal form. So is a reserving load with `req_rb`=`req_rt`. Stores are not checked for either register clash.
- R7: A reserving request (`req_reserve`=1) whose address is not 16-byte aligned reports `exc_cause`=2 with `exc_half`=0 and issues no memory operation.
- R8: A non-reserving load with `req_big_endian`=0 and `req_prefixed`=0 and an address that is not 16-byte aligned also reports `exc_cause`=2. Big-endian loads, prefixed loads and stores that are not reserving are issued unaligned, with no exception.
- R9: A half is tagged `mem_atomic` when address bits 2:0 are zero and bit 3 equals the half index. `mem_atomic_last` is set only on an atomic half 1.
- R10: When `mem_fault` is high at the acceptance of a half, the block reports `exc_cause`=3 with `exc_half` set to that half, one cycle later. A fault on half 0 prevents half 1 from being issued.
- R11: An illegal form takes priority over an alignment trap. A trapped request produces its `exc_valid` pulse in the cycle after acceptance.
- R12: While `mem_valid`=1 and `mem_ready`=0, the memory-port fields stay unchanged and `mem_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_reserve | input | 1 | Reserving load or conditional store |
| req_prefixed | input | 1 | Prefixed instruction form |
| req_big_endian | input | 1 | 1 = big-endian mode |
| req_mode32 | input | 1 | 32-bit addressing mode |
| req_ea | input | ADDR_W | Effective address of the quadword |
| req_rt | input | REG_W | Register-pair number (must be even) |
| req_ra | input | REG_W | Base register number |
| req_rb | input | REG_W | Index register number |
| mem_valid | output | 1 | Half operation presented |
| mem_ready | input | 1 | Memory accepts the half |
| mem_fault | input | 1 | Memory reports a fault with the acceptance |
| mem_addr | output | ADDR_W | Address of this half |
| mem_reg | output | REG_W | Register used by this half |
| mem_store | output | 1 | Half is a store |
| mem_half | output | 1 | Half index (0 or 1) |
| mem_atomic | output | 1 | Half belongs to an atomic quadword access |
| mem_atomic_last | output | 1 | Final half of an atomic access |
| mem_reserve | output | 1 | Reservation flag for this half |
| done_valid | output | 1 | Request completed without exception |
| exc_valid | output | 1 | Request ended in an exception |
| exc_cause | output | 2 | 1 illegal form, 2 alignment, 3 memory fault |
| exc_half | output | 1 | Half at which the exception was raised |

## Verification
Two pairs of checks can apply to the same request:

- **Illegal form and alignment trap at acceptance.** Both can be true for one request. The bench provokes this with an odd or clashing register number combined with a misaligned reserving address, and expects only the illegal cause, with no memory traffic.
- **Memory fault and the advance to half 1.** A memory fault can arrive in the same cycle that half 0 is accepted, which is also when the sequencer would move on to half 1. The bench raises the fault exactly at that acceptance. It judges the result by the absence of any half 1 operation on the port and by an exception tagged with half 0. The same fault raised on half 1 must report half 1.

// File: rtl/qw_pkg.sv
package qw_pkg;

  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_ILLEGAL  = 2'd1,
    EXC_ALIGN    = 2'd2,
    EXC_MEMFAULT = 2'd3
  } qw_exc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HALF0 = 2'd1,
    ST_HALF1 = 2'd2,
    ST_RESP  = 2'd3
  } qw_state_e;

  // The odd register goes first only for the little-endian, non-prefixed form.
  function automatic logic odd_reg_first(input logic big_endian, input logic prefixed);
    return !big_endian && !prefixed;
  endfunction

  // Trap a misaligned load when its first register write could clobber the base register.
  function automatic logic load_needs_align(input logic is_store, input logic big_endian,
                                            input logic prefixed);
    return !is_store && odd_reg_first(big_endian, prefixed);
  endfunction

endpackage

// File: rtl/qw_form_check.sv
module qw_form_check #(
  parameter int REG_W = 5
) (
  input  logic             is_store,
  input  logic             reserve,
  input  logic [REG_W-1:0] rt,
  input  logic [REG_W-1:0] ra,
  input  logic [REG_W-1:0] rb,
  output logic             odd_pair,
  output logic             base_clash,
  output logic             index_clash,
  output logic             illegal
);

  always_comb begin
    odd_pair    = rt[0];
    base_clash  = !is_store && (ra == rt);
    index_clash = !is_store && reserve && (rb == rt);
    illegal     = odd_pair || base_clash || index_clash;
  end

endmodule

// File: rtl/qw_half_addr.sv
module qw_half_addr #(
  parameter int ADDR_W   = 64,
  parameter int OFS_W    = 3,
  parameter int NARROW_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              mode32,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1
);

  localparam int HI_W = ADDR_W - OFS_W;
  localparam logic [HI_W-1:0]   HI_ONE   = {{(HI_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] LOW_MASK = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  // Step to the next doubleword: bump the upper field, keep the byte offset.
  function automatic logic [ADDR_W-1:0] next_half(input logic [ADDR_W-1:0] a);
    logic [HI_W-1:0] hi;
    hi = a[ADDR_W-1:OFS_W] + HI_ONE;
    return {hi, a[OFS_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] narrow(input logic [ADDR_W-1:0] a, input logic m32);
    return m32 ? (a & LOW_MASK) : a;
  endfunction

  always_comb begin
    addr0 = narrow(base, mode32);
    addr1 = narrow(next_half(base), mode32);
  end

endmodule

// File: rtl/qw_align_check.sv
module qw_align_check #(
  parameter int OFS_W = 3
) (
  input  logic [OFS_W:0] low_bits,
  input  logic           half,
  output logic           aligned
);

  // A half is aligned when the byte offset is zero and bit OFS_W matches the half index.
  always_comb begin
    aligned = (low_bits[OFS_W-1:0] == '0) && (low_bits[OFS_W] == half);
  end

endmodule

// File: rtl/qw_split_seq.sv
module qw_split_seq
  import qw_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 5,
  parameter int HALF_BYTES = 8,
  parameter int NARROW_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_store,
  input  logic              req_reserve,
  input  logic              req_prefixed,
  input  logic              req_big_endian,
  input  logic              req_mode32,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [REG_W-1:0]  req_rt,
  input  logic [REG_W-1:0]  req_ra,
  input  logic [REG_W-1:0]  req_rb,
  output logic              mem_valid,
  input  logic              mem_ready,
  input  logic              mem_fault,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_reg,
  output logic              mem_store,
  output logic              mem_half,
  output logic              mem_atomic,
  output logic              mem_atomic_last,
  output logic              mem_reserve,
  output logic              done_valid,
  output logic              exc_valid,
  output logic [1:0]        exc_cause,
  output logic              exc_half
);

  localparam int OFS_W = $clog2(HALF_BYTES);

  qw_state_e         state;
  qw_exc_e           r_exc;
  logic              r_exc_half;
  logic              r_store;
  logic              r_reserve;
  logic              r_prefixed;
  logic              r_be;
  logic              r_mode32;
  logic [ADDR_W-1:0] r_base;
  logic [REG_W-1:0]  r_rt;

  // Named internal events.
  logic              accept;
  logic              handshake;
  logic              form_illegal;
  logic              odd_pair;
  logic              base_clash;
  logic              index_clash;
  logic              acc_aligned;
  logic              align_trap;
  logic              cur_half;
  logic              odd_first;
  logic [ADDR_W-1:0] addr0;
  logic [ADDR_W-1:0] addr1;
  logic [1:0]        half_aligned;

  assign accept    = req_valid && req_ready;
  assign handshake = mem_valid && mem_ready;

  // Illegal-form screening on the incoming request.
  qw_form_check #(.REG_W(REG_W)) form_i (
    .is_store    (req_is_store),
    .reserve     (req_reserve),
    .rt          (req_rt),
    .ra          (req_ra),
    .rb          (req_rb),
    .odd_pair    (odd_pair),
    .base_clash  (base_clash),
    .index_clash (index_clash),
    .illegal     (form_illegal)
  );

  // Alignment of the incoming address, judged as half 0.
  qw_align_check #(.OFS_W(OFS_W)) acc_align_i (
    .low_bits (req_ea[OFS_W:0]),
    .half     (1'b0),
    .aligned  (acc_aligned)
  );

  assign align_trap = !acc_aligned &&
                      (req_reserve || load_needs_align(req_is_store, req_big_endian, req_prefixed));

  // Addresses of both halves from the captured base.
  qw_half_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .NARROW_W(NARROW_W)) addr_i (
    .base   (r_base),
    .mode32 (r_mode32),
    .addr0  (addr0),
    .addr1  (addr1)
  );

  // Atomic tagging per half.
  for (genvar h = 0; h < 2; h++) begin : g_half_align
    logic [ADDR_W-1:0] ha;
    assign ha = (h == 0) ? addr0 : addr1;
    qw_align_check #(.OFS_W(OFS_W)) half_align_i (
      .low_bits (ha[OFS_W:0]),
      .half     (h[0]),
      .aligned  (half_aligned[h])
    );
  end

  assign cur_half  = (state == ST_HALF1);
  assign odd_first = odd_reg_first(r_be, r_prefixed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      r_exc      <= EXC_NONE;
      r_exc_half <= 1'b0;
      r_store    <= 1'b0;
      r_reserve  <= 1'b0;
      r_prefixed <= 1'b0;
      r_be       <= 1'b0;
      r_mode32   <= 1'b0;
      r_base     <= '0;
      r_rt       <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            r_store    <= req_is_store;
            r_reserve  <= req_reserve;
            r_prefixed <= req_prefixed;
            r_be       <= req_big_endian;
            r_mode32   <= req_mode32;
            r_base     <= req_ea;
            r_rt       <= req_rt;
            r_exc_half <= 1'b0;
            if (form_illegal) begin
              r_exc <= EXC_ILLEGAL;
              state <= ST_RESP;
            end else if (align_trap) begin
              r_exc <= EXC_ALIGN;
              state <= ST_RESP;
            end else begin
              r_exc <= EXC_NONE;
              state <= ST_HALF0;
            end
          end
        end
        ST_HALF0: begin
          if (handshake) begin
            if (mem_fault) begin
              r_exc      <= EXC_MEMFAULT;
              r_exc_half <= 1'b0;
              state      <= ST_RESP;
            end else begin
              state <= ST_HALF1;
            end
          end
        end
        ST_HALF1: begin
          if (handshake) begin
            if (mem_fault) begin
              r_exc      <= EXC_MEMFAULT;
              r_exc_half <= 1'b1;
            end
            state <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready       = (state == ST_IDLE);
    mem_valid       = (state == ST_HALF0) || (state == ST_HALF1);
    mem_half        = cur_half;
    mem_addr        = cur_half ? addr1 : addr0;
    mem_reg         = {r_rt[REG_W-1:1], cur_half ^ odd_first};
    mem_store       = r_store;
    mem_reserve     = r_reserve;
    mem_atomic      = half_aligned[cur_half];
    mem_atomic_last = half_aligned[cur_half] && cur_half;
    done_valid      = (state == ST_RESP) && (r_exc == EXC_NONE);
    exc_valid       = (state == ST_RESP) && (r_exc != EXC_NONE);
    exc_cause       = r_exc;
    exc_half        = r_exc_half;
  end

  // ---------------- assertions ----------------

  // R1
  exclusive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_valid, done_valid, exc_valid}));

  // R11
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_valid && !mem_half) || exc_valid);

  // R12
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_reg)
                                  && $stable(mem_half));

  // R2
  offset_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !mem_fault && !mem_half) |=>
      mem_valid && mem_half && (mem_addr[OFS_W-1:0] == $past(mem_addr[OFS_W-1:0])));

  // R4
  pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !mem_fault && !mem_half) |=> (mem_reg == ($past(mem_reg) ^ {{(REG_W-1){1'b0}}, 1'b1})));

  // R9
  last_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_atomic_last |-> mem_atomic && mem_half);

  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && mem_fault && !mem_half) |=> !mem_valid && exc_valid && !exc_half);

  // R5
  early_exc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_cause != 2'd3) |-> !exc_half);

endmodule

// File: tb/qw_split_seq_tb_top.sv
`timescale 1ns/1ps
module qw_split_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_is_store = 1'b0;
  logic        req_reserve = 1'b0;
  logic        req_prefixed = 1'b0;
  logic        req_big_endian = 1'b0;
  logic        req_mode32 = 1'b0;
  logic [63:0] req_ea = '0;
  logic [4:0]  req_rt = '0;
  logic [4:0]  req_ra = '0;
  logic [4:0]  req_rb = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_fault = 1'b0;
  logic [63:0] mem_addr;
  logic [4:0]  mem_reg;
  logic        mem_store, mem_half, mem_atomic, mem_atomic_last, mem_reserve;
  logic        done_valid, exc_valid;
  logic [1:0]  exc_cause;
  logic        exc_half;

  always #10 clk = ~clk;

  qw_split_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_store(req_is_store), .req_reserve(req_reserve),
    .req_prefixed(req_prefixed), .req_big_endian(req_big_endian),
    .req_mode32(req_mode32), .req_ea(req_ea),
    .req_rt(req_rt), .req_ra(req_ra), .req_rb(req_rb),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_fault(mem_fault),
    .mem_addr(mem_addr), .mem_reg(mem_reg), .mem_store(mem_store),
    .mem_half(mem_half), .mem_atomic(mem_atomic), .mem_atomic_last(mem_atomic_last),
    .mem_reserve(mem_reserve),
    .done_valid(done_valid), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_half(exc_half)
  );

  typedef struct {
    int          kind;   // 0 memory half, 1 done, 2 exception
    logic [63:0] addr;
    logic [4:0]  rg;
    logic        half;
    logic        store;
    logic        atomic;
    logic        last;
    logic        rsv;
    logic [1:0]  cause;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  int   fault_at = -1;
  int   stall_len = 0;
  bit   finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic push_mem(input logic [63:0] a, input logic [4:0] rg, input logic h,
                          input logic st, input logic at, input logic rsv, input string tag);
    exp_t e;
    e.kind = 0; e.addr = a; e.rg = rg; e.half = h; e.store = st;
    e.atomic = at; e.last = at && h; e.rsv = rsv; e.cause = 2'd0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_end(input int kind, input logic [1:0] cause, input logic h, input string tag);
    exp_t e;
    e.kind = kind; e.addr = '0; e.rg = '0; e.half = h; e.store = 1'b0;
    e.atomic = 1'b0; e.last = 1'b0; e.rsv = 1'b0; e.cause = cause; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Driver: computes expectations from the requirements, then offers the request.
  task automatic send(input bit st, input bit rsv, input bit pref, input bit be, input bit m32,
                      input logic [63:0] ea, input logic [4:0] rt, input logic [4:0] ra,
                      input logic [4:0] rb, input int fault, input int stall, input string tag);
    bit          illegal, misal, trap, odd1st, at;
    logic [63:0] a0, a1, mask;
    logic [4:0]  g0, g1;
    illegal = rt[0] || (!st && ra == rt) || (!st && rsv && rb == rt);   // R5 R6
    misal   = (ea % 16) != 0;
    trap    = misal && (rsv || (!st && !pref && !be));                   // R7 R8
    mask    = m32 ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;   // R3
    a0      = ea & mask;
    a1      = (ea + 64'd8) & mask;                                       // R2
    odd1st  = !be && !pref;                                              // R4
    g0      = odd1st ? (rt | 5'd1) : rt;
    g1      = odd1st ? rt : (rt | 5'd1);
    at      = !misal;                                                    // R9
    if (illegal) push_end(2, 2'd1, 1'b0, tag);                           // R11
    else if (trap) push_end(2, 2'd2, 1'b0, tag);
    else begin
      push_mem(a0, g0, 1'b0, st, at, rsv, tag);
      if (fault == 0) push_end(2, 2'd3, 1'b0, tag);                      // R10
      else begin
        push_mem(a1, g1, 1'b1, st, at, rsv, tag);
        if (fault == 1) push_end(2, 2'd3, 1'b1, tag);
        else push_end(1, 2'd0, 1'b0, tag);
      end
    end
    fault_at  = fault;
    stall_len = stall;
    do @(negedge clk); while (!req_ready);
    req_is_store = st; req_reserve = rsv; req_prefixed = pref;
    req_big_endian = be; req_mode32 = m32; req_ea = ea;
    req_rt = rt; req_ra = ra; req_rb = rb; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // Monitor and memory responder: pops expected items as results appear.
  initial begin
    bit          seen = 0;
    int          waited = 0;
    logic [63:0] held_addr = '0;
    logic [4:0]  held_reg = '0;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (mem_valid) begin
        if (!seen) begin
          seen = 1; waited = 0; held_addr = mem_addr; held_reg = mem_reg;
        end else begin
          check(mem_addr == held_addr && mem_reg == held_reg, "R12", "stalled fields",
                mem_addr, held_addr);
        end
        if (waited < stall_len) begin
          mem_ready = 1'b0; mem_fault = 1'b0; waited++;
        end else begin
          mem_ready = 1'b1;
          mem_fault = (fault_at == int'(mem_half));
          seen = 0;
          if (exp_q.size() == 0) check(0, "R1", "unexpected memory half", 64'(mem_half), 64'd0);
          else begin
            e = exp_q.pop_front();
            if (e.kind != 0) check(0, e.tag, "memory half instead of end", 64'd0, 64'(e.kind));
            else begin
              check(mem_half == e.half, "R1", {e.tag, " half"}, 64'(mem_half), 64'(e.half));
              check(mem_addr == e.addr, "R2", {e.tag, " addr"}, mem_addr, e.addr);
              check(mem_reg == e.rg, "R4", {e.tag, " reg"}, 64'(mem_reg), 64'(e.rg));
              check(mem_store == e.store && mem_reserve == e.rsv, "R1", {e.tag, " flags"},
                    {62'd0, mem_store, mem_reserve}, {62'd0, e.store, e.rsv});
              check(mem_atomic == e.atomic && mem_atomic_last == e.last, "R9",
                    {e.tag, " atomic"}, {62'd0, mem_atomic, mem_atomic_last},
                    {62'd0, e.atomic, e.last});
            end
          end
        end
      end else begin
        mem_ready = 1'b0; mem_fault = 1'b0; seen = 0;
      end
      if (done_valid || exc_valid) begin
        if (exp_q.size() == 0) check(0, "R1", "unexpected response", 64'(exc_cause), 64'd0);
        else begin
          e = exp_q.pop_front();
          if (e.kind == 1) check(done_valid && !exc_valid, "R1", {e.tag, " done"},
                                 {62'd0, done_valid, exc_valid}, 64'd2);
          else if (e.kind == 2) begin
            check(exc_valid && exc_cause == e.cause, "R11", {e.tag, " cause"},
                  64'(exc_cause), 64'(e.cause));
            check(exc_half == e.half, "R10", {e.tag, " exc half"}, 64'(exc_half), 64'(e.half));
          end else check(0, e.tag, "response instead of memory half", 64'd1, 64'd0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !mem_valid && !done_valid && !exc_valid, "R1", "reset state",
          {60'd0, req_ready, mem_valid, done_valid, exc_valid}, 64'h8);

    // args: st rsv pref be m32 ea rt ra rb fault stall
    send(0,0,0,1,0, 64'h1000, 5'd4, 5'd2, 5'd3, -1, 0, "R4 BE load aligned");
    send(0,0,0,0,0, 64'h1010, 5'd6, 5'd2, 5'd3, -1, 0, "R4 LE load odd first");
    send(0,0,1,0,0, 64'h1020, 5'd6, 5'd2, 5'd3, -1, 1, "R4 LE prefixed load");
    send(1,0,0,0,0, 64'h1030, 5'd10, 5'd2, 5'd3, -1, 2, "R12 LE store stalled");
    send(1,0,0,1,0, 64'h2004, 5'd12, 5'd2, 5'd3, -1, 0, "R8 BE store unaligned");
    send(0,0,0,0,0, 64'h3008, 5'd14, 5'd2, 5'd3, -1, 0, "R8 LE load trap");
    send(0,0,0,1,0, 64'h3008, 5'd14, 5'd2, 5'd3, -1, 0, "R9 BE load bit3 set");
    send(0,0,1,0,0, 64'h3006, 5'd14, 5'd2, 5'd3, -1, 0, "R8 prefixed load no trap");
    send(0,1,0,0,0, 64'h4000, 5'd8, 5'd1, 5'd2, -1, 0, "R9 reserving load atomic");
    send(1,1,0,1,0, 64'h4008, 5'd8, 5'd1, 5'd2, -1, 0, "R7 reserving store misaligned");
    send(1,1,1,1,0, 64'h4001, 5'd8, 5'd1, 5'd2, -1, 0, "R7 reserving store low bits");
    send(1,0,0,1,0, 64'h5000, 5'd3, 5'd1, 5'd2, -1, 0, "R5 odd pair");
    send(0,0,0,1,0, 64'h5000, 5'd6, 5'd6, 5'd2, -1, 0, "R6 load base clash");
    send(1,0,0,1,0, 64'h5000, 5'd6, 5'd6, 5'd6, -1, 0, "R6 store clash ignored");
    send(0,1,0,1,0, 64'h5000, 5'd6, 5'd1, 5'd6, -1, 0, "R6 reserving index clash");
    send(0,0,0,1,0, 64'h5000, 5'd6, 5'd1, 5'd6, -1, 0, "R6 plain load index ignored");
    send(0,1,0,0,0, 64'h5004, 5'd6, 5'd6, 5'd6, -1, 0, "R11 illegal beats align");
    send(0,0,0,1,1, 64'hFFFF_FFFF_FFFF_FFF8, 5'd2, 5'd1, 5'd3, -1, 0, "R3 narrow wrap");
    send(0,0,0,1,0, 64'h0000_0000_FFFF_FFF8, 5'd2, 5'd1, 5'd3, -1, 0, "R2 carry past bit32");
    send(1,0,0,0,1, 64'hABCD_0000_1234_5670, 5'd20, 5'd1, 5'd3, -1, 1, "R3 narrow upper cleared");
    send(0,0,0,1,0, 64'h6000, 5'd16, 5'd1, 5'd3, 0, 0, "R10 fault half0");
    send(1,0,0,0,0, 64'h6010, 5'd16, 5'd1, 5'd3, 1, 1, "R10 fault half1");
    send(0,0,0,1,0, 64'h6020, 5'd18, 5'd1, 5'd3, -1, 0, "R1 after faults");

    repeat (3) @(negedge clk);
    check(req_ready && !mem_valid, "R1", "idle at end", {62'd0, req_ready, mem_valid}, 64'h2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule